// File: doc/BRIEF.md
# Two-Tier DMA Channel Priority Arbiter

This block picks which DMA channel is serviced next. Every channel brings a request line, and the arbiter keeps one priority-level bit per channel. A requesting channel whose bit is set belongs to the high tier, and the high tier always beats the default tier. Within a tier, the lowest channel number wins. The result comes out registered, as three signals: a one-hot grant vector, the binary channel index and a valid flag.

Once a grant is valid, the arbiter keeps it while the transfer runs. It picks again only when the transfer-boundary input is pulsed. When no grant is valid, the arbiter picks on every cycle, so a new request is served without waiting for a boundary. Priority bits are changed through two write strobes: one sets bits and one clears bits, and each comes with its own channel mask. No read-modify-write is needed.

Top module: `dma_prio_arb`

## Requirements
- R1: After reset the grant vector is zero, the index is zero, valid is low, and every channel is at default priority (priority bit 0).
- R2: When any requesting channel has its priority bit at 1 (high tier), the grant goes to a high-tier channel, ahead of every requesting default-tier channel.
- R3: Within the winning tier, the requesting channel with the lowest channel number receives the grant. The same rule applies in the high tier and in the default tier.
- R4: When a pick happens and no channel requests, the grant vector becomes zero, the index becomes zero and valid goes low.
- R5: The grant vector has at most one bit set. Valid is high exactly when a grant bit is set. The index is the bit position of the set grant bit.
- R6: While valid is high and the boundary input is low, the grant, the index and valid do not change, whatever the requests or priority bits do.
- R7: A pick happens on every clock edge where valid is low or the boundary input is high. The pick uses the requests and priority bits present at that edge, and its result appears on the outputs after that edge.
- R8: On an edge where the set strobe is high, each channel selected in the set mask gets priority bit 1. On an edge where the clear strobe is high, each channel selected in the clear mask gets priority bit 0. If both strobes select the same channel in the same cycle, that bit ends at 1. Channels selected by neither mask keep their bit.
- R9: A priority write affects picks from the edge after the write edge onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_req | input | NCH | Per-channel request lines |
| xfer_bnd | input | 1 | Transfer boundary; allows a new pick while a grant is held |
| prio_set_we | input | 1 | Set strobe for priority bits |
| prio_set_mask | input | NCH | Channels to raise to the high tier |
| prio_clr_we | input | 1 | Clear strobe for priority bits |
| prio_clr_mask | input | NCH | Channels to return to the default tier |
| gnt | output | NCH | One-hot grant vector |
| gnt_idx | output | IW | Binary index of the granted channel |
| gnt_vld | output | 1 | A grant is present |

## Verification
The bench builds the arbiter with NCH = 8, so every request pattern fits in 256 values. It sweeps all 256 request patterns against eight distinct priority-bit patterns, and a bench-side tier-and-lowest-index model supplies each expected grant. The small width also allows directed checks: an empty request set, a high-tier channel above a lower-numbered default channel, writes that set and clear the same bit at once, and a held grant during request changes without a boundary.

// File: rtl/dma_prio_arb.sv
module dma_prio_arb #(
  parameter int NCH = 32,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] chan_req,
  input  logic           xfer_bnd,
  input  logic           prio_set_we,
  input  logic [NCH-1:0] prio_set_mask,
  input  logic           prio_clr_we,
  input  logic [NCH-1:0] prio_clr_mask,
  output logic [NCH-1:0] gnt,
  output logic [IW-1:0]  gnt_idx,
  output logic           gnt_vld
);

  logic [NCH-1:0] prio_q;
  logic [NCH-1:0] hi_req, pool, pick;
  logic [IW-1:0]  pick_idx;
  logic           upd;

  wire [NCH-1:0] set_v = prio_set_we ? prio_set_mask : '0;
  wire [NCH-1:0] clr_v = prio_clr_we ? prio_clr_mask : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) prio_q <= '0;
    else        prio_q <= (prio_q & ~clr_v) | set_v;
  end

  assign hi_req = chan_req & prio_q;
  assign pool   = (|hi_req) ? hi_req : chan_req;
  assign pick   = pool & (~pool + 1'b1);
  assign upd    = !gnt_vld || xfer_bnd;

  always_comb begin
    pick_idx = '0;
    for (int i = 0; i < NCH; i++)
      if (pick[i]) pick_idx = pick_idx | IW'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt     <= '0;
      gnt_idx <= '0;
      gnt_vld <= 1'b0;
    end else if (upd) begin
      gnt     <= pick;
      gnt_idx <= pick_idx;
      gnt_vld <= |chan_req;
    end
  end

  p_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  p_vld_r5: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld == (gnt != '0));
  p_idx_r5: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld |-> gnt[gnt_idx]);
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_vld && !xfer_bnd) |=> ($stable(gnt) && $stable(gnt_idx) && gnt_vld));
  p_tier_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && (hi_req != '0)) |=> ((gnt & $past(prio_q)) != '0));
  p_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && (chan_req != '0)) |=> (((gnt - 1'b1) & $past(pool)) == '0));
  p_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && (chan_req == '0)) |=> (!gnt_vld && gnt_idx == '0));
  p_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    prio_set_we |=> ((prio_q & $past(prio_set_mask)) == $past(prio_set_mask)));
  p_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (prio_clr_we && !prio_set_we) |=> ((prio_q & $past(prio_clr_mask)) == '0));

endmodule

// File: tb/test_dma_prio_arb.sv
`timescale 1ns/1ps
module test_dma_prio_arb;
  localparam int N = 8;
  localparam int W = 3;

  logic         clk = 0, rst_n = 0;
  logic [N-1:0] req = '0, smask = '0, cmask = '0;
  logic         bnd = 0, swe = 0, cwe = 0;
  logic [N-1:0] gnt;
  logic [W-1:0] idx;
  logic         vld;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dma_prio_arb #(.NCH(N)) i_dma_prio_arb (
    .clk(clk), .rst_n(rst_n), .chan_req(req), .xfer_bnd(bnd),
    .prio_set_we(swe), .prio_set_mask(smask),
    .prio_clr_we(cwe), .prio_clr_mask(cmask),
    .gnt(gnt), .gnt_idx(idx), .gnt_vld(vld));

  function automatic int model(logic [N-1:0] r, logic [N-1:0] p);
    logic [N-1:0] h = r & p;
    logic [N-1:0] s = (h != 0) ? h : r;
    for (int i = 0; i < N; i++) if (s[i]) return i;
    return -1;
  endfunction

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic expect_win(string tag, int w);
    check({tag, " vld"}, vld, w >= 0);
    check({tag, " gnt"}, gnt, (w >= 0) ? (1 << w) : 0);
    check({tag, " idx"}, idx, (w >= 0) ? w : 0);
  endtask

  task automatic wr_prio(logic s, logic [N-1:0] sm, logic c, logic [N-1:0] cm);
    @(negedge clk);
    swe = s; smask = sm; cwe = c; cmask = cm;
    @(negedge clk);
    swe = 0; cwe = 0; smask = '0; cmask = '0;
  endtask

  task automatic pick(logic [N-1:0] r);
    @(negedge clk);
    req = r; bnd = 1;
    @(negedge clk);
    bnd = 0;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=1 exp=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] pr;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check("R1 vld", vld, 0); check("R1 gnt", gnt, 0); check("R1 idx", idx, 0);
    // R1: all default after reset -> lowest wins even with ch0 low
    pick(8'b1010_0100); expect_win("R1 R3 default", 2);
    // R4 no request
    pick(8'h00); expect_win("R4 idle", -1);
    // R7 idle picks without boundary
    @(negedge clk); req = 8'b0100_0000;
    @(negedge clk); expect_win("R7 idle pick", 6);
    // R6 hold: lower channel arrives, requests drop, no boundary
    req = 8'b0000_0001; @(negedge clk); expect_win("R6 hold1", 6);
    req = 8'h00;        @(negedge clk); expect_win("R6 hold2", 6);
    wr_prio(1, 8'h01, 0, 0);
    req = 8'h01;        @(negedge clk); expect_win("R6 hold3", 6);
    wr_prio(0, 0, 1, 8'hFF);
    // R7 boundary repicks with that cycle's req
    pick(8'b0011_0000); expect_win("R7 bnd", 4);
    // R8 set, R2 tier
    wr_prio(1, 8'b0010_0000, 0, 0);
    pick(8'b0010_0100); expect_win("R8 R2 set", 5);
    // R8 clear one, set another; unmasked unchanged
    wr_prio(1, 8'b0100_0000, 1, 8'b0010_0000);
    pick(8'b0110_0100); expect_win("R8 clr", 6);
    // R8 both strobes same bit -> set wins
    wr_prio(1, 8'b0000_1000, 1, 8'b0000_1000);
    pick(8'b0000_1001); expect_win("R8 both", 3);
    // R3 within high tier
    pick(8'b0100_1001); expect_win("R3 hi tier", 3);
    // R9 write applies from following edge
    @(negedge clk); req = 8'b1000_0010; bnd = 1; swe = 1; smask = 8'h80;
    cwe = 1; cmask = 8'h7F;
    @(negedge clk); swe = 0; cwe = 0;
    expect_win("R9 same edge", 1);
    @(negedge clk); bnd = 0;
    expect_win("R9 next edge", 7);
    // sweep: R2 R3 R4 R5 R7
    for (int p = 0; p < 8; p++) begin
      pr = N'((p * 37 + p * p * 11) & 8'hFF);
      wr_prio(1, pr, 1, 8'hFF);
      for (int r = 0; r < 256; r++) begin
        pick(N'(r));
        expect_win("R2 R3 R5 sweep", model(N'(r), pr));
      end
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule